// File: doc/BRIEF.md
# Stepwise I2C Master Byte Engine

This block is a byte-oriented I2C bus master that software drives one bus step at a time through a small register set. There is a control register, a data register and a read-only status register. Software arms a step by writing the control or data register. It then clears the interrupt flag. The engine performs exactly one bus action: a START, a repeated START, one address or data byte out, one data byte in, or a STOP. When the action is done it raises the flag, posts an 8-bit status code that says what happened, and holds SCL low until software clears the flag again.

Bit timing comes from an external quarter-bit enable (`tick_i`). Each bit on the bus takes four ticks: SCL is low for two and released for two. The engine drives both lines open-drain, so an output enable of 1 pulls the line low. It reads SDA back for acknowledge bits, for received data and to detect lost arbitration. When another master wins the bus, the engine drops both lines at once, reports the loss and sends no STOP.

Top module: `i2cm_engine`

## Requirements
- R1: After reset the status register reads 0xF8, the control register reads 0x00, the data register reads 0x00 and neither SCL nor SDA is pulled low.
- R2: When a step completes, the interrupt flag (control bit 3) goes to 1, SCL stays pulled low, and the engine starts nothing more and does not change either line while the flag stays set. Writing 0 to bit 3 clears the flag. Writing 1 to bit 3 never sets it.
- R3: With the enable bit (bit 6) set, writing the START bit (bit 5) while the bus is idle and the flag is clear sends a START condition and posts 0x08. The START bit then reads back as 0.
- R4: After a START, clearing the flag sends the data register as an address byte: address in bits 7:1, and bit 0 = 1 means read. The status is 0x18 for write+ACK, 0x20 for write+NAK, 0x40 for read+ACK and 0x48 for read+NAK.
- R5: In write mode, clearing the flag sends the data register MSB first and posts 0x28 when the slave ACKs or 0x30 when it NAKs.
- R6: In read mode, clearing the flag receives one byte MSB first into the data register. The master answers with ACK and posts 0x50 when the ACK-enable bit (bit 2) is 1. It answers with NAK and posts 0x58 when bit 2 is 0.
- R7: Setting START while the flag is set and then clearing the flag produces a repeated START and posts 0x10.
- R8: Setting the STOP bit (bit 4) and clearing the flag sends a STOP condition. Afterwards the STOP bit reads 0, the status is 0xF8, both lines are released and the flag stays clear.
- R9: If the engine releases SDA while sending but samples it low while SCL is high, it posts 0x38, sets the flag, releases both lines in the same cycle and sends no STOP.
- R10: While the enable bit is 0, a START request is ignored: no flag, status stays 0xF8 and both lines stay released.
- R11: The interrupt output is high exactly when the flag is set and the interrupt-enable bit (bit 7) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Quarter-bit timing enable from an external divider |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 = control, 1 = data |
| reg_wdata_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register contents |
| data_o | output | 8 | Data register contents |
| status_o | output | 8 | Status code |
| irq_o | output | 1 | Interrupt request |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The bench pairs the engine with a behavioural slave that watches both lines. It targets the codes that are easy to confuse:
- The NAK variants of the address and data steps. A design that ignored the sampled acknowledge would post 0x18 or 0x28 in their place.
- The ACK-enable switch on the last received byte. If it were ignored, the slave would keep driving data and the code would stay 0x50.
- The repeated START while the flag is set. A design that waited for idle would stall or post 0x08.
- An SDA line forced low during an address bit. A design that kept driving would hold SCL, or emit a STOP instead of posting 0x38.
- The stall rule, checked on every clock while a transaction is open. A design that went on after a step would let SCL rise with the flag still set.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BYTE, S_HOLD, S_STOP
  } seq_st_e;

  localparam int B_ACK   = 2;
  localparam int B_IFLG  = 3;
  localparam int B_STOP  = 4;
  localparam int B_START = 5;
  localparam int B_EN    = 6;
  localparam int B_IEN   = 7;

  localparam logic [7:0] C_START  = 8'h08;
  localparam logic [7:0] C_RSTART = 8'h10;
  localparam logic [7:0] C_AW_ACK = 8'h18;
  localparam logic [7:0] C_AW_NAK = 8'h20;
  localparam logic [7:0] C_DT_ACK = 8'h28;
  localparam logic [7:0] C_DT_NAK = 8'h30;
  localparam logic [7:0] C_LOST   = 8'h38;
  localparam logic [7:0] C_AR_ACK = 8'h40;
  localparam logic [7:0] C_AR_NAK = 8'h48;
  localparam logic [7:0] C_DR_ACK = 8'h50;
  localparam logic [7:0] C_DR_NAK = 8'h58;
  localparam logic [7:0] C_IDLE   = 8'hF8;
endpackage

// File: rtl/i2cm_phase.sv
module i2cm_phase #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  output logic [PH_W-1:0] ph,
  output logic            ph_last
);
  localparam logic [PH_W-1:0] PH_MAX = '1;

  logic [PH_W-1:0] ph_q, ph_n;
  logic            ph_en;

  always_comb begin
    ph_n  = ph_q;
    ph_en = 1'b0;
    if (!run) begin
      ph_n  = '0;
      ph_en = (ph_q != '0);
    end else if (tick) begin
      ph_n  = ph_q + 1'b1;
      ph_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_n;
  end

  assign ph      = ph_q;
  assign ph_last = run && tick && (ph_q == PH_MAX);
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  input  logic          clr_start,
  input  logic          clr_stop,
  input  logic          iflg_set,
  input  logic          stat_we,
  input  logic [7:0]    stat_code,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  output logic [7:0]    ctrl,
  output logic [DW-1:0] data,
  output logic [7:0]    status
);
  logic [7:0]    ctl_q, ctl_n;
  logic [DW-1:0] dat_q, dat_n;
  logic [7:0]    sts_q;
  logic          ctl_en, dat_en;

  always_comb begin
    ctl_n = ctl_q;
    if (we && !sel) begin
      ctl_n = {wdata[7:4], ctl_q[B_IFLG] & wdata[3], wdata[2], 2'b00};
    end
    if (clr_start) ctl_n[B_START] = 1'b0;
    if (clr_stop)  ctl_n[B_STOP]  = 1'b0;
    if (iflg_set)  ctl_n[B_IFLG]  = 1'b1;
    ctl_en = (we && !sel) || clr_start || clr_stop || iflg_set;

    dat_n  = rx_load ? rx_byte : wdata;
    dat_en = rx_load || (we && sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dat_q <= '0;
      sts_q <= C_IDLE;
    end else begin
      if (ctl_en)  ctl_q <= ctl_n;
      if (dat_en)  dat_q <= dat_n;
      if (stat_we) sts_q <= stat_code;
    end
  end

  assign ctrl   = ctl_q;
  assign data   = dat_q;
  assign status = sts_q;
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start_b,
  input  logic            stop_b,
  input  logic            iflg,
  input  logic            ack_en,
  input  logic [DW-1:0]   data_q,
  input  logic            sda_in,
  input  logic            tick,
  input  logic [PH_W-1:0] ph,
  input  logic            ph_last,
  output logic            run,
  output logic            scl_drv,
  output logic            sda_drv,
  output logic            clr_start,
  output logic            clr_stop,
  output logic            iflg_set,
  output logic            stat_we,
  output logic [7:0]      stat_code,
  output logic            rx_load,
  output logic [DW-1:0]   rx_byte
);
  localparam int              BIT_W   = $clog2(DW + 1);
  localparam logic [BIT_W-1:0] ACK_POS = BIT_W'(DW);
  localparam logic [PH_W-1:0]  PH_SMP  = PH_W'(2);

  seq_st_e         st_q, st_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [DW-1:0]   sh_q, sh_n;
  logic            first_q, first_n, rd_q, rd_n, tx_q, tx_n;
  logic            rs_q, rs_n, hold_q, hold_n, nak_q, nak_n;
  logic            smp, hi_half;

  assign hi_half = ph[PH_W-1];
  assign smp     = tick && (ph == PH_SMP) && (st_q == S_BYTE);
  assign run     = (st_q == S_START) || (st_q == S_BYTE) || (st_q == S_STOP);
  assign rx_byte = sh_q;

  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    unique case (st_q)
      S_START: begin scl_drv = rs_q && (ph == '0); sda_drv = hi_half; end
      S_BYTE: begin
        scl_drv = !hi_half;
        if (bit_q == ACK_POS) sda_drv = tx_q ? 1'b0 : ack_en;
        else                  sda_drv = tx_q ? !sh_q[DW-1] : 1'b0;
      end
      S_HOLD:  begin scl_drv = 1'b1; sda_drv = hold_q; end
      S_STOP:  begin scl_drv = (ph == '0); sda_drv = !hi_half; end
      default: ;
    endcase
  end

  always_comb begin
    st_n = st_q; bit_n = bit_q; sh_n = sh_q; first_n = first_q;
    rd_n = rd_q; tx_n = tx_q; rs_n = rs_q; hold_n = hold_q; nak_n = nak_q;
    clr_start = 1'b0; clr_stop = 1'b0; iflg_set = 1'b0;
    stat_we = 1'b0; stat_code = C_IDLE; rx_load = 1'b0;
    if (!en) begin
      st_n = S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start_b && !iflg) begin
            st_n = S_START; rs_n = 1'b0;
          end else if (stop_b) begin
            clr_stop = 1'b1; stat_we = 1'b1; stat_code = C_IDLE;
          end
        end
        S_START: if (ph_last) begin
          st_n = S_HOLD; hold_n = 1'b1; first_n = 1'b1;
          clr_start = 1'b1; iflg_set = 1'b1; stat_we = 1'b1;
          stat_code = rs_q ? C_RSTART : C_START;
        end
        S_HOLD: if (!iflg) begin
          if (stop_b) st_n = S_STOP;
          else if (start_b) begin
            st_n = S_START; rs_n = 1'b1;
          end else begin
            st_n  = S_BYTE; bit_n = '0; sh_n = data_q;
            tx_n  = first_q || !rd_q;
            if (first_q) rd_n = data_q[0];
          end
        end
        S_BYTE: begin
          if (smp) begin
            if (bit_q == ACK_POS) nak_n = sda_in;
            else if (!tx_q) sh_n = {sh_q[DW-2:0], sda_in};
            else if (sh_q[DW-1] && !sda_in) begin
              st_n = S_IDLE; iflg_set = 1'b1;
              stat_we = 1'b1; stat_code = C_LOST;
            end
          end
          if (ph_last) begin
            if (bit_q == ACK_POS) begin
              st_n = S_HOLD; hold_n = 1'b0; first_n = 1'b0;
              iflg_set = 1'b1; stat_we = 1'b1; rx_load = !tx_q;
              if (first_q)   stat_code = rd_q ? (nak_q ? C_AR_NAK : C_AR_ACK)
                                              : (nak_q ? C_AW_NAK : C_AW_ACK);
              else if (tx_q) stat_code = nak_q ? C_DT_NAK : C_DT_ACK;
              else           stat_code = ack_en ? C_DR_ACK : C_DR_NAK;
            end else begin
              bit_n = bit_q + 1'b1;
              if (tx_q) sh_n = {sh_q[DW-2:0], 1'b0};
            end
          end
        end
        S_STOP: if (ph_last) begin
          st_n = S_IDLE; clr_stop = 1'b1; stat_we = 1'b1; stat_code = C_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bit_q <= '0; sh_q <= '0; first_q <= 1'b0; rd_q <= 1'b0;
      tx_q <= 1'b0; rs_q <= 1'b0; hold_q <= 1'b0; nak_q <= 1'b0;
    end else begin
      st_q <= st_n; bit_q <= bit_n; sh_q <= sh_n; first_q <= first_n; rd_q <= rd_n;
      tx_q <= tx_n; rs_q <= rs_n; hold_q <= hold_n; nak_q <= nak_n;
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PH_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          reg_we_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [7:0]    ctrl_o,
  output logic [DW-1:0] data_o,
  output logic [7:0]    status_o,
  output logic          irq_o,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  logic [1:0]      rst_sync;
  logic            rst_q;
  logic [PH_W-1:0] ph;
  logic            ph_last, run;
  logic            clr_start, clr_stop, iflg_set, stat_we, rx_load;
  logic [7:0]      stat_code;
  logic [DW-1:0]   rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  i2cm_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_q), .run(run), .tick(tick_i), .ph(ph), .ph_last(ph_last)
  );

  i2cm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q), .we(reg_we_i), .sel(reg_sel_i), .wdata(reg_wdata_i),
    .clr_start(clr_start), .clr_stop(clr_stop), .iflg_set(iflg_set),
    .stat_we(stat_we), .stat_code(stat_code), .rx_load(rx_load), .rx_byte(rx_byte),
    .ctrl(ctrl_o), .data(data_o), .status(status_o)
  );

  i2cm_seq #(.DW(DW), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_q), .en(ctrl_o[B_EN]), .start_b(ctrl_o[B_START]),
    .stop_b(ctrl_o[B_STOP]), .iflg(ctrl_o[B_IFLG]), .ack_en(ctrl_o[B_ACK]),
    .data_q(data_o), .sda_in(sda_i), .tick(tick_i), .ph(ph), .ph_last(ph_last),
    .run(run), .scl_drv(scl_oe_o), .sda_drv(sda_oe_o), .clr_start(clr_start),
    .clr_stop(clr_stop), .iflg_set(iflg_set), .stat_we(stat_we),
    .stat_code(stat_code), .rx_load(rx_load), .rx_byte(rx_byte)
  );

  assign irq_o = ctrl_o[B_IFLG] && ctrl_o[B_IEN];
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we_i,
  input logic       reg_sel_i,
  input logic [7:0] ctrl_o,
  input logic [7:0] status_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[3] && $past(ctrl_o[3]) && ctrl_o[6] && $past(ctrl_o[6]))
      |-> ($stable(scl_oe_o) && $stable(sda_oe_o)));

  p_start_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 8'h08 && $past(status_o) != 8'h08) |-> (!ctrl_o[5] && ctrl_o[3]));

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_o[4]) && ctrl_o[6] && !$past(reg_we_i && !reg_sel_i))
      |-> (status_o == 8'hF8 && !scl_oe_o && !sda_oe_o));

  p_lost_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 8'h38 && $past(status_o) != 8'h38)
      |-> (!scl_oe_o && !sda_oe_o && ctrl_o[3]));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[6] |=> (!scl_oe_o && !sda_oe_o));
endmodule

bind i2cm_engine i2cm_chk u_chk (
  .clk(clk), .rst_n(rst_q), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .ctrl_o(ctrl_o), .status_o(status_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/sim_i2cm_engine.sv
`timescale 1ns/1ps
module sim_i2cm_engine;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic we = 1'b0, sel = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] ctrl_o, data_o, status_o;
  logic irq_o, scl_oe, sda_oe;
  logic s_drv = 1'b0, force_low = 1'b0, nak_data = 1'b0;
  logic scl_ln, sda_ln;
  int checks = 0, fails = 0, tcnt = 0;
  bit bus_owned = 1'b0, done = 1'b0;
  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  assign scl_ln = ~scl_oe;
  assign sda_ln = ~sda_oe & ~s_drv & ~force_low;

  i2cm_engine u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .ctrl_o(ctrl_o), .data_o(data_o), .status_o(status_o),
    .irq_o(irq_o), .sda_i(sda_ln), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  always @(negedge clk) begin
    tcnt = (tcnt == 2) ? 0 : tcnt + 1;
    tick = (tcnt == 2);
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Behavioural slave: reacts to line levels only.
  int bc = -1;
  bit act = 0, isad = 0, srd = 0, matched = 0, mack = 0;
  bit pscl = 1, psda = 1;
  logic [7:0] sh = '0, txb = '0, rdv = 8'h90;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pscl && scl_ln && psda && !sda_ln) begin
        act = 1; bc = -1; isad = 1; s_drv = 0;
      end else if (pscl && scl_ln && !psda && sda_ln) begin
        act = 0; s_drv = 0;
      end else if (act && !pscl && scl_ln) begin
        if (bc >= 0 && bc < 8 && (isad || !srd)) sh = {sh[6:0], sda_ln};
        if (bc == 8 && !isad && srd) mack = !sda_ln;
      end else if (act && pscl && !scl_ln) begin
        if (bc == 8) begin
          bc = 0;
          if (isad) begin
            if (matched) begin
              isad = 0;
              if (srd) begin txb = rdv; rdv++; s_drv = !txb[7]; end
              else s_drv = 0;
            end else begin act = 0; s_drv = 0; end
          end else if (srd) begin
            if (mack) begin txb = rdv; rdv++; s_drv = !txb[7]; end
            else begin act = 0; s_drv = 0; end
          end else s_drv = 0;
        end else begin
          bc = bc + 1;
          if (bc == 8) begin
            if (isad) begin matched = (sh[7:1] == SLV); srd = sh[0]; s_drv = matched; end
            else if (!srd) begin rxq.push_back(sh); s_drv = !nak_data; end
            else s_drv = 0;
          end else if (!isad && srd) s_drv = !txb[7 - bc];
          else s_drv = 0;
        end
      end
      pscl = scl_ln; psda = sda_ln;
    end
  end

  // Every-clock model compare: an open transaction stalls with SCL low (R2).
  always @(negedge clk) begin
    if (rst_n && bus_owned && ctrl_o[3]) chk("R2 scl held low", {7'd0, scl_ln}, 8'd0);
  end

  task automatic wr(input logic s, input logic [7:0] v);
    @(negedge clk); we = 1; sel = s; wd = v;
    @(negedge clk); we = 0;
  endtask

  task automatic wait_flag(input string tag);
    int n = 0;
    while (!ctrl_o[3] && n < 3000) begin @(negedge clk); n++; end
    chk({tag, " flag"}, {7'd0, ctrl_o[3]}, 8'd1);
  endtask

  task automatic go(input string tag);
    wr(0, ctrl_o & 8'hF7);
    wait_flag(tag);
  endtask

  task automatic do_start(input string tag, input logic [7:0] code);
    wr(0, ctrl_o | 8'h20);
    if (ctrl_o[3]) go(tag); else wait_flag(tag);
    chk({tag, " status"}, status_o, code);
    chk({tag, " start bit self-clear"}, {7'd0, ctrl_o[5]}, 8'd0);
    bus_owned = 1;
  endtask

  task automatic do_stop(input string tag);
    int n = 0;
    bus_owned = 0;
    wr(0, (ctrl_o | 8'h10) & 8'hF7);
    while (ctrl_o[4] && n < 3000) begin @(negedge clk); n++; end
    chk({tag, " stop bit self-clear"}, {7'd0, ctrl_o[4]}, 8'd0);
    chk({tag, " idle status"}, status_o, 8'hF8);
    chk({tag, " flag clear"}, {7'd0, ctrl_o[3]}, 8'd0);
    chk({tag, " lines free"}, {6'd0, scl_ln, sda_ln}, 8'd3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 status", status_o, 8'hF8);
    chk("R1 ctrl", ctrl_o, 8'h00);
    chk("R1 data", data_o, 8'h00);
    chk("R1 lines", {6'd0, scl_oe, sda_oe}, 8'd0);

    // R10: disabled engine ignores START
    wr(0, 8'h20);
    repeat (200) @(negedge clk);
    chk("R10 no flag", {7'd0, ctrl_o[3]}, 8'd0);
    chk("R10 status", status_o, 8'hF8);
    chk("R10 lines", {6'd0, scl_ln, sda_ln}, 8'd3);

    // R2: writing 1 to flag does not set it
    wr(0, 8'hCC);
    chk("R2 flag write-one", {7'd0, ctrl_o[3]}, 8'd0);

    // Write then repeated-start read, R3..R7
    do_start("R3 start", 8'h08);
    chk("R11 irq", {7'd0, irq_o}, 8'd1);
    repeat (60) @(negedge clk);
    chk("R2 stall status", status_o, 8'h08);
    chk("R2 stall flag", {7'd0, ctrl_o[3]}, 8'd1);
    wr(1, {SLV, 1'b0});
    go("R4 addr W");
    chk("R4 addr W ack", status_o, 8'h18);
    wr(1, 8'h3C);
    go("R5 data");
    chk("R5 data ack", status_o, 8'h28);
    chk("R5 byte seen", (rxq.size() > 0) ? rxq[$] : 8'hxx, 8'h3C);
    do_start("R7 rstart", 8'h10);
    wr(1, {SLV, 1'b1});
    go("R4 addr R");
    chk("R4 addr R ack", status_o, 8'h40);
    go("R6 rx ack");
    chk("R6 rx ack status", status_o, 8'h50);
    chk("R6 rx byte0", data_o, 8'h90);
    wr(0, ctrl_o & 8'hFB);
    go("R6 rx nak");
    chk("R6 rx nak status", status_o, 8'h58);
    chk("R6 rx byte1", data_o, 8'h91);
    do_stop("R8");
    wr(0, ctrl_o | 8'h04);

    // Address NAK codes
    do_start("R3 start2", 8'h08);
    wr(1, 8'h22);
    go("R4 addr W nak");
    chk("R4 addr W nak status", status_o, 8'h20);
    do_stop("R8 b");
    do_start("R3 start3", 8'h08);
    wr(1, 8'h23);
    go("R4 addr R nak");
    chk("R4 addr R nak status", status_o, 8'h48);
    do_stop("R8 c");

    // Data NAK
    do_start("R3 start4", 8'h08);
    wr(1, {SLV, 1'b0});
    go("R4 addr W2");
    chk("R4 addr W2 ack", status_o, 8'h18);
    nak_data = 1;
    wr(1, 8'h55);
    go("R5 data nak");
    chk("R5 data nak status", status_o, 8'h30);
    nak_data = 0;
    do_stop("R8 d");

    // R9 arbitration loss on the address MSB
    do_start("R3 start5", 8'h08);
    wr(1, {SLV, 1'b0});
    bus_owned = 0;
    force_low = 1;
    go("R9 lost");
    chk("R9 lost status", status_o, 8'h38);
    chk("R9 released", {6'd0, scl_oe, sda_oe}, 8'd0);
    repeat (60) @(negedge clk);
    chk("R9 no stop", status_o, 8'h38);
    force_low = 0;
    repeat (10) @(negedge clk);
    wr(0, ctrl_o & 8'hF7);
    repeat (40) @(negedge clk);
    chk("R9 stays idle", {6'd0, scl_oe, sda_oe}, 8'd0);
    do_start("R3 after lost", 8'h08);
    do_stop("R8 e");

    // R11 with interrupt masked
    wr(0, 8'h44);
    do_start("R11 start", 8'h08);
    chk("R11 irq masked", {7'd0, irq_o}, 8'd0);
    do_stop("R8 f");

    finish_run();
  end
endmodule